// File: doc/BRIEF.md
# Interrupt Acknowledge Gate

This block sits between a processor's instruction sequencer and its interrupt controller. It decides at which instruction boundary a pending interrupt request may be acknowledged. Each time an instruction completes, the sequencer raises a boundary strobe and presents a decoded class for that instruction. The gate refuses acknowledgement at the boundary of any instruction that carries a one-instruction hold-off. These are the signed-operation prefix, the protected stack/flag/enable instructions, the read-modify-write logical instructions, and the two trap kinds. It also refuses while the transfer server is partway through a cycle, and while its own response sequence is still running.

When it grants a request that has the standard route, the gate issues a one-cycle acknowledge and runs a vector-fetch-and-call sequence. The length of that sequence depends on the address mode and on where the stack lives. At the end the gate pulses a done strobe. A request routed to the transfer server is acknowledged but does not start the sequence.

The controller has two states. `ST_IDLE` waits for a grant. On a grant for a standard-route request it moves to `ST_CALL` and loads the response length. `ST_CALL` counts down one state time per clock. When the count reaches zero it returns to `ST_IDLE` and pulses done. A grant for a server-route request leaves the controller in `ST_IDLE`.

Top module: `ig_ack_gate`

## Requirements
- R1: Reset (`rst_n` low) clears `irq_ack`, `resp_busy` and `resp_done` at once and abandons any running response, so no `resp_done` follows it.
- R2: `irq_ack` is a single-cycle pulse in the cycle after a clock edge at which all of these hold: `instr_done` is high, `irq_pending` is high, the finishing class is non-holding and no response is running. Non-holding classes are 0, 6 and 7. A pending request with no boundary is never acknowledged.
- R3: Class 1 (signed-operation prefix byte 0xFE) blocks acknowledgement at its boundary.
- R4: Class 2 (protected instructions: interrupt enable and disable, server enable and disable, push and pop of all registers or of flags) blocks acknowledgement at its boundary.
- R5: Class 3 (read-modify-write AND, OR and XOR in word or byte form) blocks acknowledgement at its boundary.
- R6: Class 4 (software trap) and class 5 (unimplemented-opcode trap) block acknowledgement at their boundary.
- R7: A request held off by a holding class is acknowledged at the next boundary whose class does not hold. A chain of holding classes keeps deferring it.
- R8: While `server_busy` is high, no acknowledge is issued.
- R9: For a standard-route grant, `resp_done` pulses for one cycle exactly N rising edges after the edge that raises `irq_ack`. N is 11 for {`addr_wide`,`stack_ext`}=00, 13 for 01, 15 for 10 and 18 for 11, with the mode and stack inputs sampled at the grant. `resp_busy` is high from the `irq_ack` cycle until the cycle before `resp_done`.
- R10: A grant with `irq_via_server` high pulses `irq_ack` but leaves `resp_busy` low and produces no `resp_done`.
- R11: Boundaries that occur while `resp_busy` is high produce no acknowledge and do not alter the response length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Instruction boundary strobe |
| instr_kind | input | 3 | Decoded class of the instruction finishing at this boundary |
| irq_pending | input | 1 | An interrupt request is waiting |
| irq_via_server | input | 1 | Request is serviced by the transfer server, not by vector-and-call |
| addr_wide | input | 1 | 1 = 1-Mbyte address mode, 0 = 64-Kbyte mode |
| stack_ext | input | 1 | 1 = stack in external memory |
| server_busy | input | 1 | A transfer-server cycle is in progress |
| irq_ack | output | 1 | Acknowledge pulse |
| resp_busy | output | 1 | Vector-and-call response running |
| resp_done | output | 1 | One-cycle end-of-response strobe |

## Verification
The hardest cases to reach from the ports are a boundary that lands while a response is already counting, and a run of consecutive holding instructions with the request still pending. To reach the first, the bench keeps `irq_pending` high after a grant and fires an ordinary boundary on the very next cycle. It then checks both that no second acknowledge appears and that the done strobe still arrives on the original edge count. To reach the second, the bench issues back-to-back prefix, protected and logical boundaries ahead of an ordinary one. A reset in the middle of a response then checks that the abandoned sequence never reports done.

// File: rtl/ig_pkg.sv
package ig_pkg;

    typedef enum logic [2:0] {
        K_PLAIN    = 3'd0,
        K_SIGNPFX  = 3'd1,
        K_GUARDED  = 3'd2,
        K_LOGICRMW = 3'd3,
        K_SWTRAP   = 3'd4,
        K_BADOP    = 3'd5,
        K_SPARE6   = 3'd6,
        K_SPARE7   = 3'd7
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALL = 1'b1
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ig_defer_decode.sv
module ig_defer_decode #(
    parameter int unsigned KIND_W    = 3,
    parameter logic [(1<<KIND_W)-1:0] HOLD_MASK = 8'b0011_1110
) (
    input  logic [KIND_W-1:0] kind,
    output logic              hold
);
    localparam int unsigned N_KINDS = 1 << KIND_W;

    logic [N_KINDS-1:0] hit;

    generate
        for (genvar g = 0; g < N_KINDS; g++) begin : g_kind
            assign hit[g] = HOLD_MASK[g] && (kind == KIND_W'(g));
        end
    endgenerate

    assign hold = |hit;

endmodule

// File: rtl/ig_resp_timer.sv
module ig_resp_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ig_ack_gate.sv
module ig_ack_gate #(
    parameter int unsigned LEN_NARROW_INT = 11,
    parameter int unsigned LEN_NARROW_EXT = 13,
    parameter int unsigned LEN_WIDE_INT   = 15,
    parameter int unsigned LEN_WIDE_EXT   = 18,
    parameter int unsigned KIND_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic [KIND_W-1:0] instr_kind,
    input  logic              irq_pending,
    input  logic              irq_via_server,
    input  logic              addr_wide,
    input  logic              stack_ext,
    input  logic              server_busy,
    output logic              irq_ack,
    output logic              resp_busy,
    output logic              resp_done
);
    import ig_pkg::*;

    localparam int unsigned MAX_LEN = max2(max2(LEN_NARROW_INT, LEN_NARROW_EXT),
                                           max2(LEN_WIDE_INT, LEN_WIDE_EXT));
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_e       state_q, state_d;
    logic             hold;
    logic             grant;
    logic             start_call;
    logic             cnt_zero;
    logic [CNT_W-1:0] len_sel;

    ig_defer_decode #(
        .KIND_W (KIND_W)
    ) u_decode (
        .kind (instr_kind),
        .hold (hold)
    );

    always_comb begin
        unique case ({addr_wide, stack_ext})
            2'b00:   len_sel = CNT_W'(LEN_NARROW_INT - 1);
            2'b01:   len_sel = CNT_W'(LEN_NARROW_EXT - 1);
            2'b10:   len_sel = CNT_W'(LEN_WIDE_INT - 1);
            default: len_sel = CNT_W'(LEN_WIDE_EXT - 1);
        endcase
    end

    assign grant      = instr_done && irq_pending && !hold && !server_busy
                        && (state_q == ST_IDLE);
    assign start_call = grant && !irq_via_server;

    ig_resp_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_call),
        .load_val (len_sel),
        .run      (state_q == ST_CALL),
        .zero     (cnt_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_call) state_d = ST_CALL;
            ST_CALL: if (cnt_zero)   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_ack   <= 1'b0;
            resp_done <= 1'b0;
        end else begin
            irq_ack   <= grant;
            resp_done <= (state_q == ST_CALL) && cnt_zero;
        end
    end

    assign resp_busy = (state_q == ST_CALL);

endmodule

// File: rtl/ig_ack_gate_chk.sv
module ig_ack_gate_chk #(
    parameter int unsigned KIND_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_done,
    input logic [KIND_W-1:0] instr_kind,
    input logic              irq_pending,
    input logic              irq_via_server,
    input logic              server_busy,
    input logic              irq_ack,
    input logic              resp_busy,
    input logic              resp_done
);
    // R2
    ack_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(instr_done && irq_pending));

    // R3 R4 R5 R6
    ack_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !($past(instr_kind) >= KIND_W'(1) && $past(instr_kind) <= KIND_W'(5)));

    // R8
    ack_server_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !$past(server_busy));

    // R11
    no_ack_in_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !$past(resp_busy));

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> ($past(resp_busy) && !resp_busy));

    // R9
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resp_busy) |-> resp_done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    // R10
    server_no_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && $past(irq_via_server)) |-> !resp_busy);

endmodule

bind ig_ack_gate ig_ack_gate_chk #(.KIND_W(KIND_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_done     (instr_done),
    .instr_kind     (instr_kind),
    .irq_pending    (irq_pending),
    .irq_via_server (irq_via_server),
    .server_busy    (server_busy),
    .irq_ack        (irq_ack),
    .resp_busy      (resp_busy),
    .resp_done      (resp_done)
);

// File: tb/sim_ig_ack_gate.sv
`timescale 1ns/1ps
module sim_ig_ack_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_done = 1'b0;
    logic [2:0] instr_kind = 3'd0;
    logic       irq_pending = 1'b0;
    logic       irq_via_server = 1'b0;
    logic       addr_wide = 1'b0;
    logic       stack_ext = 1'b0;
    logic       server_busy = 1'b0;
    logic       irq_ack;
    logic       resp_busy;
    logic       resp_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ig_ack_gate u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_done     (instr_done),
        .instr_kind     (instr_kind),
        .irq_pending    (irq_pending),
        .irq_via_server (irq_via_server),
        .addr_wide      (addr_wide),
        .stack_ext      (stack_ext),
        .server_busy    (server_busy),
        .irq_ack        (irq_ack),
        .resp_busy      (resp_busy),
        .resp_done      (resp_done)
    );

    typedef struct packed {
        logic [2:0] kind;
        logic       pend;
        logic       srv;
        logic       wide;
        logic       ext;
        logic       sbusy;
        logic       exp_ack;
        logic [4:0] exp_len;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd11, 4'd9},  // R9 narrow internal
        '{3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd13, 4'd9},  // R9 narrow external
        '{3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd15, 4'd9},  // R9 wide internal
        '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd18, 4'd9},  // R9 wide external
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd3},  // R3 prefix
        '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd4},  // R4 protected
        '{3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5},  // R5 logic rmw
        '{3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd6},  // R6 soft trap
        '{3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  4'd6},  // R6 bad opcode
        '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  4'd10}, // R10 server route
        '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  4'd8},  // R8 server busy
        '{3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd2},  // R2 nothing pending
        '{3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd11, 4'd2}   // R2 spare class
    };

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic boundary(input logic [2:0] kind, output logic got_ack);
        instr_kind = kind;
        instr_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr_done = 1'b0;
        got_ack = irq_ack;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!resp_done && n < 40) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_dones(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (resp_done) n++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic a;
        int   n;
        string rq;

        // R1 reset state
        @(negedge clk);
        check("R1", "ack in reset", int'(irq_ack), 0);
        check("R1", "busy in reset", int'(resp_busy), 0);
        check("R1", "done in reset", int'(resp_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            rq = $sformatf("R%0d", VECS[v].req);
            irq_pending    = VECS[v].pend;
            irq_via_server = VECS[v].srv;
            addr_wide      = VECS[v].wide;
            stack_ext      = VECS[v].ext;
            server_busy    = VECS[v].sbusy;
            boundary(VECS[v].kind, a);
            irq_pending = 1'b0;
            server_busy = 1'b0;
            check(rq, $sformatf("vec %0d ack", v), int'(a), int'(VECS[v].exp_ack));
            if (VECS[v].exp_len != 0) begin
                check(rq, $sformatf("vec %0d busy at ack", v), int'(resp_busy), 1);
                wait_done(n);
                check(rq, $sformatf("vec %0d edges to done", v), n, int'(VECS[v].exp_len));
                @(negedge clk);
                check(rq, $sformatf("vec %0d done width", v), int'(resp_done), 0);
            end else begin
                check(rq, $sformatf("vec %0d busy", v), int'(resp_busy), 0);
                count_dones(20, n);
                check(rq, $sformatf("vec %0d stray done", v), n, 0);
            end
            irq_via_server = 1'b0;
            @(negedge clk);
        end

        // R7: chain of holding classes then an ordinary one
        irq_pending = 1'b1;
        addr_wide = 1'b1; stack_ext = 1'b1;
        boundary(3'd1, a); check("R7", "chain prefix", int'(a), 0);
        boundary(3'd2, a); check("R7", "chain protected", int'(a), 0);
        boundary(3'd3, a); check("R7", "chain logic", int'(a), 0);
        boundary(3'd0, a); check("R7", "ack after chain", int'(a), 1);
        irq_pending = 1'b0;
        wait_done(n);
        check("R7", "length after chain", n, 18);
        @(negedge clk);

        // R2: pending without any boundary
        irq_pending = 1'b1;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq_ack) n++;
        end
        check("R2", "ack without boundary", n, 0);

        // R11: boundary during response, mode change ignored
        addr_wide = 1'b0; stack_ext = 1'b0;
        boundary(3'd0, a); check("R11", "first ack", int'(a), 1);
        addr_wide = 1'b1; stack_ext = 1'b1;
        boundary(3'd0, a); check("R11", "ack during call", int'(a), 0);
        irq_pending = 1'b0;
        wait_done(n);
        check("R11", "length unchanged", n + 1, 11);
        @(negedge clk);

        // R8: blocked while server busy, then granted
        irq_pending = 1'b1; irq_via_server = 1'b1;
        server_busy = 1'b1;
        boundary(3'd0, a); check("R8", "ack with server busy", int'(a), 0);
        server_busy = 1'b0;
        boundary(3'd0, a); check("R8", "ack once server free", int'(a), 1);
        check("R10", "no busy for server route", int'(resp_busy), 0);
        irq_pending = 1'b0; irq_via_server = 1'b0;
        @(negedge clk);

        // R1: reset during a response
        addr_wide = 1'b0; stack_ext = 1'b0;
        irq_pending = 1'b1;
        boundary(3'd0, a); check("R1", "ack before reset", int'(a), 1);
        irq_pending = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "busy cleared by reset", int'(resp_busy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        count_dones(20, n);
        check("R1", "no done after reset", n, 0);

        finish_run();
    end

endmodule